// File: doc/BRIEF.md
# Dual-Output Programmable Clock Divider

This block derives two divided clock waveforms from one fast master clock. Both waveforms are produced as registered levels in the `clk` domain. `clk` runs at twice the master rate, so one master period equals two `clk` cycles. Each output has its own power-of-two prescaler.

Output 0 is the first prescaler's waveform. Output 1 takes the second prescaler's waveform and divides it further by any integer ratio from 1 to 1025. A gate sits in front of each output. It can switch the output on or off and lets only whole pulses through.

The gates are driven by one of two sources, chosen by a mode bit: enable bits held in a control register, or two external control pins. A global power-down input silences both outputs. An option also lets control pin 1 request power-down. Settings are loaded through a single-cycle parallel write port and may be changed while the block runs. A new ratio takes effect only when the current output period is complete.

Top module: `dual_clk_divider`

## Requirements
- R1: The 2-bit prescaler code s gives a divide ratio of 2^s, so 00, 01, 10 and 11 mean 1, 2, 4 and 8. Output 0 then has a period of 2^(s+1) clk cycles and is high for 2^s of them. The prescaler code for output 0 sits in write address 0, bits [1:0]; the code for output 1 sits in bits [3:2].
- R2: Write address 1 holds the code N-1 for output 1's ratio N. Output 1's period is N prescaled periods, where one prescaled period is 2^(s1+1) clk cycles. With N = 1, output 1 is the prescaled waveform unchanged.
- R3: The ratio code ranges from 0 to 1024. Any written value above 1024, including values up to the full 16-bit write width, is stored as 1024 (N = 1025).
- R4: Every period begins with its low phase. For N of 2 or more, output 1 is high for floor(N/2) prescaled periods, which gives 50% duty for even N and (N-1)/2 high periods for odd N.
- R5: A gate changes between enabled and disabled only while the source waveform is low. Every pulse that leaves the block is therefore a full high phase.
- R6: While power-down is active, both outputs stop. Each output finishes its current high phase first and then stays low.
- R7: Write address 2 is the control register: bit 0 enables output 0, bit 1 enables output 1, bit 2 selects pin mode, and bit 3 makes control pin 1 a power-down request. In pin mode, pin 0 gates output 0 and pin 1 gates output 1. When bit 3 is also set, both outputs follow pin 0.
- R8: A new prescaler code or ratio code takes effect only at the end of a complete period of the affected waveform. No shortened high phase appears during the change.
- R9: The reset is synchronous and active high. It clears every counter and every setting. Both outputs stay low and disabled until they are enabled again.
- R10: A write to address 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, twice the master rate |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Write strobe for the settings port |
| cfg_addr | input | ADDR_W (2) | Register address for a write |
| cfg_wdata | input | DATA_W (16) | Write data |
| ctl_pin | input | 2 | External gate or power-down control pins |
| pd_req | input | 1 | Global power-down request, active high |
| clk_out0 | output | 1 | Output 0, prescaled master clock |
| clk_out1 | output | 1 | Output 1, prescaled and divided clock |

## Verification
The assertions assume that `ctl_pin`, `pd_req` and the write port are already synchronous to `clk` and change only between its rising edges. Under that assumption, a gate or power-down decision is sampled once per cycle against a stable source level. The bench drives every input on the falling edge of `clk`, so this holds throughout the run. The assertions also assume that reset is applied before any output is expected to be quiet. The bench raises reset from time zero and again in the middle of the run.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

  typedef enum logic [1:0] {
    REG_PRESCALE = 2'd0,
    REG_RATIO    = 2'd1,
    REG_CONTROL  = 2'd2,
    REG_SPARE    = 2'd3
  } reg_addr_e;

  typedef struct packed {
    logic pd_via_pin;
    logic pin_mode;
    logic en1;
    logic en0;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/clkdiv_cfg.sv
module clkdiv_cfg
  import clkdiv_pkg::*;
#(
  parameter int SEL_W   = 2,
  parameter int DIV_W   = 11,
  parameter int DIV_MAX = 1024,
  parameter int ADDR_W  = 2,
  parameter int DATA_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [SEL_W-1:0]  sel0,
  output logic [SEL_W-1:0]  sel1,
  output logic [DIV_W-1:0]  ratio_code,
  output ctrl_t             ctrl
);

  localparam logic [DATA_W-1:0] LIMIT_WIDE = DATA_W'(DIV_MAX);
  localparam logic [DIV_W-1:0]  LIMIT      = DIV_W'(DIV_MAX);

  logic [DIV_W-1:0] code_clamped;

  // Saturate over the full data width, not only the low DIV_W bits.
  always_comb begin
    if (wdata > LIMIT_WIDE) code_clamped = LIMIT;
    else                    code_clamped = wdata[DIV_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel0       <= '0;
      sel1       <= '0;
      ratio_code <= '0;
      ctrl       <= '0;
    end else if (wr) begin
      case (reg_addr_e'(addr[1:0]))
        REG_PRESCALE: begin
          sel0 <= wdata[SEL_W-1:0];
          sel1 <= wdata[2*SEL_W-1:SEL_W];
        end
        REG_RATIO:    ratio_code <= code_clamped;
        REG_CONTROL:  ctrl       <= ctrl_t'(wdata[CTRL_W-1:0]);
        default:      ;
      endcase
    end
  end

endmodule

// File: rtl/clkdiv_prescaler.sv
module clkdiv_prescaler #(
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] sel_req,
  output logic             level,
  output logic             period_end
);

  localparam int MAX_EXP = (1 << SEL_W) - 1;
  localparam int CNT_W   = MAX_EXP + 1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] mask;
  logic [SEL_W-1:0] sel_act;

  // Terminal count of the active ratio: the low sel_act+1 bits all set.
  always_comb begin
    for (int i = 0; i < CNT_W; i++) begin
      mask[i] = (i <= int'(sel_act));
    end
  end

  assign period_end = (cnt == mask);
  assign level      = cnt[sel_act];

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      sel_act <= '0;
    end else if (period_end) begin
      cnt     <= '0;
      sel_act <= sel_req;
    end else begin
      cnt <= cnt + CNT_W'(1);
    end
  end

endmodule

// File: rtl/clkdiv_ratio.sv
module clkdiv_ratio #(
  parameter int DIV_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             src_level,
  input  logic             src_end,
  input  logic [DIV_W-1:0] code_req,
  output logic             level,
  output logic [DIV_W-1:0] code_act
);

  logic [DIV_W-1:0] phase;
  logic [DIV_W-1:0] low_len;
  logic             wrap;

  // Number of source periods spent low: ceil(N/2) with N = code_act + 1.
  assign low_len = (code_act >> 1) + DIV_W'(1);
  assign wrap    = (phase == code_act);

  always_comb begin
    if (code_act == '0) level = src_level;
    else                level = (phase >= low_len);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= '0;
      code_act <= '0;
    end else if (src_end) begin
      if (wrap) begin
        phase    <= '0;
        code_act <= code_req;
      end else begin
        phase <= phase + DIV_W'(1);
      end
    end
  end

endmodule

// File: rtl/clkdiv_gate.sv
module clkdiv_gate (
  input  logic clk,
  input  logic rst,
  input  logic level_in,
  input  logic en_req,
  output logic clk_out
);

  logic en_act;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_act  <= 1'b0;
      clk_out <= 1'b0;
    end else begin
      if (!level_in) en_act <= en_req;
      clk_out <= level_in & en_act;
    end
  end

endmodule

// File: rtl/clkdiv_mode.sv
module clkdiv_mode
  import clkdiv_pkg::*;
(
  input  ctrl_t      ctrl,
  input  logic [1:0] ctl_pin,
  input  logic       pd_req,
  output logic [1:0] en,
  output logic       pd_eff
);

  logic [1:0] en_src;

  always_comb begin
    pd_eff = pd_req | (ctrl.pd_via_pin & ctl_pin[1]);
    if (!ctrl.pin_mode)       en_src = {ctrl.en1, ctrl.en0};
    else if (ctrl.pd_via_pin) en_src = {ctl_pin[0], ctl_pin[0]};
    else                      en_src = ctl_pin;
    en = en_src & {2{~pd_eff}};
  end

endmodule

// File: rtl/dual_clk_divider.sv
module dual_clk_divider
  import clkdiv_pkg::*;
#(
  parameter int SEL_W   = 2,
  parameter int DIV_W   = 11,
  parameter int DIV_MAX = 1024,
  parameter int ADDR_W  = 2,
  parameter int DATA_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic [1:0]        ctl_pin,
  input  logic              pd_req,
  output logic              clk_out0,
  output logic              clk_out1
);

  localparam int N_OUT = 2;

  logic [SEL_W-1:0] sel [N_OUT];
  logic [DIV_W-1:0] ratio_code;
  logic [DIV_W-1:0] div_code_act;
  ctrl_t            ctrl;
  logic [N_OUT-1:0] pre_lvl;
  logic [N_OUT-1:0] pre_end;
  logic [N_OUT-1:0] lvl;
  logic [N_OUT-1:0] en;
  logic [N_OUT-1:0] outs;
  logic             pd_eff;

  clkdiv_cfg #(
    .SEL_W(SEL_W), .DIV_W(DIV_W), .DIV_MAX(DIV_MAX),
    .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_cfg (
    .clk(clk), .rst(rst), .wr(cfg_wr), .addr(cfg_addr), .wdata(cfg_wdata),
    .sel0(sel[0]), .sel1(sel[1]), .ratio_code(ratio_code), .ctrl(ctrl)
  );

  clkdiv_mode u_mode (
    .ctrl(ctrl), .ctl_pin(ctl_pin), .pd_req(pd_req), .en(en), .pd_eff(pd_eff)
  );

  for (genvar g = 0; g < N_OUT; g++) begin : g_path
    clkdiv_prescaler #(.SEL_W(SEL_W)) u_pre (
      .clk(clk), .rst(rst), .sel_req(sel[g]),
      .level(pre_lvl[g]), .period_end(pre_end[g])
    );
    clkdiv_gate u_gate (
      .clk(clk), .rst(rst), .level_in(lvl[g]), .en_req(en[g]), .clk_out(outs[g])
    );
  end

  assign lvl[0] = pre_lvl[0];

  clkdiv_ratio #(.DIV_W(DIV_W)) u_ratio (
    .clk(clk), .rst(rst), .src_level(pre_lvl[1]), .src_end(pre_end[1]),
    .code_req(ratio_code), .level(lvl[1]), .code_act(div_code_act)
  );

  assign clk_out0 = outs[0];
  assign clk_out1 = outs[1];

endmodule

// File: rtl/dual_clk_divider_chk.sv
module dual_clk_divider_chk #(
  parameter int DIV_W   = 11,
  parameter int DIV_MAX = 1024
) (
  input logic             clk,
  input logic             rst,
  input logic             clk_out0,
  input logic             clk_out1,
  input logic             lvl0,
  input logic             lvl1,
  input logic             pre_end0,
  input logic             pd_eff,
  input logic [DIV_W-1:0] code_act
);

  // R5: a pulse starts only at the start of a source high phase
  p_rise_whole0_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(clk_out0) |-> !$past(lvl0, 2));
  p_rise_whole1_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(clk_out1) |-> !$past(lvl1, 2));

  // R5: a pulse ends only because its source went low
  p_fall_whole0_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(clk_out0) |-> !$past(lvl0));
  p_fall_whole1_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(clk_out1) |-> !$past(lvl1));

  // R6: power-down seen during a low phase keeps the output low
  p_pd_stop0_r6: assert property (@(posedge clk) disable iff (rst)
    (pd_eff && !lvl0) |-> ##2 !clk_out0);
  p_pd_stop1_r6: assert property (@(posedge clk) disable iff (rst)
    (pd_eff && !lvl1) |-> ##2 !clk_out1);

  // R3: the ratio actually in use never exceeds the limit
  p_code_sat_r3: assert property (@(posedge clk) disable iff (rst)
    code_act <= DIV_W'(DIV_MAX));

  // R4: every prescaled period starts with its low phase
  p_start_low_r4: assert property (@(posedge clk) disable iff (rst)
    pre_end0 |=> !lvl0);

  // R9: outputs are low in the cycle after reset
  p_reset_quiet_r9: assert property (@(posedge clk)
    rst |=> (!clk_out0 && !clk_out1));

endmodule

bind dual_clk_divider dual_clk_divider_chk #(
  .DIV_W(DIV_W), .DIV_MAX(DIV_MAX)
) u_chk (
  .clk(clk), .rst(rst), .clk_out0(clk_out0), .clk_out1(clk_out1),
  .lvl0(lvl[0]), .lvl1(lvl[1]), .pre_end0(pre_end[0]),
  .pd_eff(pd_eff), .code_act(div_code_act)
);

// File: tb/test_dual_clk_divider.sv
`timescale 1ns/1ps
module test_dual_clk_divider;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_wr = 1'b0;
  logic [1:0]  cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic [1:0]  ctl_pin = 2'b11;
  logic        pd_req = 1'b0;
  logic        clk_out0;
  logic        clk_out1;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  dual_clk_divider i_dual_clk_divider (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .ctl_pin(ctl_pin), .pd_req(pd_req),
    .clk_out0(clk_out0), .clk_out1(clk_out1)
  );

  // p0, p1, data for ratio register, per0, hi0, per1, hi1
  localparam int VEC [8][7] = '{
    '{0, 0, 0,       2, 1,    2,    1},
    '{1, 0, 1,       4, 2,    4,    2},
    '{2, 1, 2,       8, 4,   12,    4},
    '{3, 2, 4,      16, 8,   40,   16},
    '{0, 3, 9,       2, 1,  160,   80},
    '{1, 0, 1024,    4, 2, 2050, 1024},
    '{2, 1, 65535,   8, 4, 4100, 2048},
    '{3, 3, 6,      16, 8,  112,   48}
  };

  function automatic logic smp(input int sel);
    return (sel == 0) ? clk_out0 : clk_out1;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = 2'(a); cfg_wdata = 16'(d);
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Period and high time between two rising edges.
  task automatic measure(input int sel, output int per, output int hi);
    logic prev, cur;
    per = 0; hi = 0;
    prev = smp(sel); cur = prev;
    for (int k = 0; k < 20000; k++) begin
      @(negedge clk); cur = smp(sel);
      if (cur && !prev) break;
      prev = cur;
    end
    if (!cur) return;
    for (int k = 0; k < 20000; k++) begin
      if (cur) hi++;
      per++;
      prev = cur;
      @(negedge clk); cur = smp(sel);
      if (cur && !prev) break;
    end
  endtask

  // Count high samples and complete pulses; flag widths other than wa or wb.
  task automatic scan(input int sel, input int cycles, input int wa, input int wb,
                      output int pulses, output int odd, output int highs);
    int run; logic seen_low; logic cur;
    run = 0; seen_low = 1'b0; pulses = 0; odd = 0; highs = 0;
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk); cur = smp(sel);
      if (cur) begin
        highs++;
        if (seen_low) run++;
      end else begin
        if (run > 0) begin
          pulses++;
          if (run != wa && run != wb) odd++;
        end
        run = 0; seen_low = 1'b1;
      end
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int per, hi, pu, od, hs, pu1, od1, hs1;

    // R9: reset state, pins high but nothing enabled
    idle(2);
    chk("R9 out0 in reset", int'(clk_out0), 0);
    chk("R9 out1 in reset", int'(clk_out1), 0);
    idle(3);
    rst = 1'b0;
    fork
      scan(0, 60, 0, 0, pu, od, hs);
      scan(1, 60, 0, 0, pu1, od1, hs1);
    join
    chk("R9 out0 quiet after reset", hs, 0);
    chk("R9 out1 quiet after reset", hs1, 0);

    // Vector table: R1 prescale, R2/R4 ratio and duty, R3 saturation
    wr(2, 3);
    for (int v = 0; v < 8; v++) begin
      wr(0, VEC[v][0] | (VEC[v][1] << 2));
      wr(1, VEC[v][2]);
      measure(1, per, hi); measure(1, per, hi);
      measure(1, per, hi);
      chk($sformatf("R2 out1 period v%0d", v), per, VEC[v][5]);
      chk($sformatf("R4 out1 high v%0d", v), hi, VEC[v][6]);
      measure(0, per, hi);
      chk($sformatf("R1 out0 period v%0d", v), per, VEC[v][3]);
      chk($sformatf("R1 out0 high v%0d", v), hi, VEC[v][4]);
    end

    // R8: prescaler change 8 -> 4 on out0, ratio change N=5 -> N=3 on out1 (p1=1)
    wr(0, 3 | (1 << 2));
    wr(1, 4);
    idle(300);
    wr(0, 2 | (1 << 2));
    wr(1, 2);
    fork
      scan(0, 400, 8, 4, pu, od, hs);
      scan(1, 400, 8, 4, pu1, od1, hs1);
    join
    chk("R8 out0 no short pulse", od, 0);
    chk("R8 out1 no short pulse", od1, 0);
    measure(1, per, hi);
    chk("R8 out1 new period", per, 12);

    // R5: toggle out0 enable at varied offsets, pulses stay width 4
    fork
      scan(0, 400, 4, 4, pu, od, hs);
      begin
        for (int i = 0; i < 6; i++) begin
          idle(5 + i); wr(2, 2);
          idle(3 + 2 * i); wr(2, 3);
        end
      end
    join
    chk("R5 whole pulses under toggling", od, 0);
    chk("R5 pulses still emitted", int'(pu > 0), 1);
    wr(2, 2);
    idle(20);
    fork
      scan(0, 100, 0, 0, pu, od, hs);
      scan(1, 100, 4, 4, pu1, od1, hs1);
    join
    chk("R5 out0 disabled stays low", hs, 0);
    chk("R5 out1 still running", int'(pu1 > 0), 1);

    // R6: global power-down
    wr(2, 3);
    idle(20);
    fork
      scan(0, 200, 4, 4, pu, od, hs);
      scan(1, 200, 4, 4, pu1, od1, hs1);
      begin idle(37); pd_req = 1'b1; end
    join
    chk("R6 out0 whole pulses on entry", od, 0);
    chk("R6 out1 whole pulses on entry", od1, 0);
    fork
      scan(0, 100, 0, 0, pu, od, hs);
      scan(1, 100, 0, 0, pu1, od1, hs1);
    join
    chk("R6 out0 stopped", hs, 0);
    chk("R6 out1 stopped", hs1, 0);
    pd_req = 1'b0;
    measure(0, per, hi);
    chk("R6 out0 resumes", per, 8);

    // R7: pin mode and pin-driven power-down
    wr(0, 1);
    wr(1, 1);
    wr(2, 4);
    ctl_pin = 2'b01;
    idle(30);
    measure(0, per, hi);
    chk("R7 pin0 gates out0", per, 4);
    scan(1, 100, 0, 0, pu, od, hs);
    chk("R7 pin1 low keeps out1 off", hs, 0);
    ctl_pin = 2'b10;
    idle(30);
    scan(0, 100, 0, 0, pu, od, hs);
    chk("R7 pin0 low keeps out0 off", hs, 0);
    measure(1, per, hi);
    chk("R7 pin1 gates out1", per, 4);
    wr(2, 12);
    ctl_pin = 2'b11;
    idle(30);
    fork
      scan(0, 100, 0, 0, pu, od, hs);
      scan(1, 100, 0, 0, pu1, od1, hs1);
    join
    chk("R7 pin1 power-down out0", hs, 0);
    chk("R7 pin1 power-down out1", hs1, 0);
    ctl_pin = 2'b01;
    idle(30);
    measure(1, per, hi);
    chk("R7 out1 follows pin0", per, 4);
    wr(2, 11);
    ctl_pin = 2'b10;
    idle(30);
    scan(0, 100, 0, 0, pu, od, hs);
    chk("R7 pin1 power-down in register mode", hs, 0);
    ctl_pin = 2'b00;
    idle(30);
    measure(0, per, hi);
    chk("R7 register mode runs", per, 4);

    // R10: spare address has no effect
    wr(3, 0);
    idle(30);
    measure(0, per, hi);
    chk("R10 out0 unchanged", per, 4);
    measure(1, per, hi);
    chk("R10 out1 unchanged", per, 4);

    // R9: reset in mid-run clears settings
    ctl_pin = 2'b11;
    @(negedge clk); rst = 1'b1;
    idle(3);
    rst = 1'b0;
    fork
      scan(0, 60, 0, 0, pu, od, hs);
      scan(1, 60, 0, 0, pu1, od1, hs1);
    join
    chk("R9 out0 low after mid-run reset", hs, 0);
    chk("R9 out1 low after mid-run reset", hs1, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule